// File: doc/BRIEF.md
# CAN Fault-Confinement Status and Interrupt Controller

This block watches the transmit and receive error counters of a CAN controller and turns them into status bits and interrupts. It decides whether the node is error-active, error-passive or bus-off, reports when either counter has reached a programmable warning limit, and raises edge-type interrupts when any of those conditions changes. A bus-off condition is not computed here; the protocol engine reports it on an input.

The block also holds the interrupt-enable register and the latched interrupt flags, and raises one combined interrupt line. Bus errors are captured as an 8-bit error code, and arbitration-lost events as a 5-bit bit position. Each capture register keeps the first event it sees until software reads the interrupt flags. Software reads the interrupt flags through the `irq_rd` strobe, and that read clears all flags.

The confinement state machine has three states: `FC_ACTIVE`, `FC_PASSIVE` and `FC_BUSOFF`. Its transitions are:
- GO_PASSIVE: `FC_ACTIVE` to `FC_PASSIVE`, when a counter reaches 128.
- RECOVER: `FC_PASSIVE` to `FC_ACTIVE`, when both counters are below 128.
- GO_OFF: any state to `FC_BUSOFF`, while the bus-off input is high.
- REJOIN: `FC_BUSOFF` to `FC_ACTIVE` or `FC_PASSIVE`, chosen by the counters, once the bus-off input is low.

Each capture register has its own two-state machine. The states are `CAP_ARMED` and `CAP_HELD`. The transition LATCH (armed to held) happens on an event. The transition REARM (held to armed) happens on an interrupt read.

Top module: `can_fault_irq_ctrl`

## Requirements
- R1: After reset the warning limit reads 96. The enables, flags, error code, arbitration position, all status outputs and `irq_o` all read 0.
- R2: `err_stat_o` goes to 1 one clock after either counter is at or above `warn_lim_o`, and goes to 0 one clock after both counters are below it. The limit is written with `lim_we`/`lim_wdata` and takes effect from the next clock.
- R3: Flag bit 2 (warning) is set when `err_stat_o` changes, in either direction. It is set on the same clock edge that updates `err_stat_o`.
- R4: `busoff_stat_o` follows `busoff_i` with one clock of delay. Every change of `busoff_i`, in either direction, sets flag bit 2.
- R5: `err_passive_o` is 1 while the node is error-passive: not bus-off, and a counter is at or above 128. Flag bit 5 is set on each GO_PASSIVE or RECOVER transition and on no other transition.
- R6: Flag bits are at these positions: 7 bus error, 6 arbitration lost, 5 error passive, 2 warning. Each enable bit sits at the same position as its flag. A flag is set only if its enable bit was 1 on that clock. The enables are written with `en_we`/`en_wdata`.
- R7: A read (`irq_rd` high for one clock) clears all flags on that edge. A flag that is set on the same edge stays set.
- R8: A bus error sets flag bit 7. It captures `ecc_o` = {type[1:0] in bits 7:6, direction in bit 5, segment in bits 4:0}. Type code 00 is a bit error, 01 a form error, 10 a stuff error and 11 any other error. Direction 1 means the node was receiving and 0 means it was transmitting.
- R9: Once an error code or arbitration position has been captured, later events leave it unchanged until an interrupt read re-arms it. An arbitration-lost event sets flag bit 6 and captures the 5-bit position on `alc_o`.
- R10: `irq_o` is 1 exactly when at least one flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tec_i | input | 8 | Transmit error counter |
| rec_i | input | 8 | Receive error counter |
| busoff_i | input | 1 | Bus-off indication from protocol engine |
| lim_we | input | 1 | Warning limit write strobe |
| lim_wdata | input | 8 | Warning limit write value |
| en_we | input | 1 | Interrupt enable write strobe |
| en_wdata | input | 8 | Interrupt enable write value |
| irq_rd | input | 1 | Interrupt register read strobe (clear and re-arm) |
| bus_err_evt | input | 1 | Bus error event pulse |
| bus_err_type | input | 2 | Error type code |
| bus_err_dir | input | 1 | 1 receiving, 0 transmitting |
| bus_err_seg | input | 5 | Frame segment of the error |
| arb_lost_evt | input | 1 | Arbitration-lost event pulse |
| arb_lost_pos | input | 5 | Bit position of lost arbitration |
| err_stat_o | output | 1 | Counter at or above warning limit |
| busoff_stat_o | output | 1 | Bus-off status |
| err_passive_o | output | 1 | Error-passive status |
| warn_lim_o | output | 8 | Current warning limit |
| irq_en_o | output | 8 | Interrupt enable register |
| irq_flags_o | output | 8 | Latched interrupt flags |
| irq_o | output | 1 | Combined interrupt line |
| ecc_o | output | 8 | Captured error code |
| alc_o | output | 5 | Captured arbitration-lost position |

## Verification
The warning path is driven with counters that land exactly on the limit and one below it, and then with a lowered limit. These patterns separate an at-or-above comparison from a strictly-above one, and they show that falling edges interrupt as well as rising ones. Stepping the transmit counter through 127, 128, 100 and 0 separates a passive crossing from a warning crossing, because each step must set exactly one of flag bits 5 and 2. Repeated bus-error and arbitration events with different codes, sent before and after a read, tell a first-event capture apart from a last-event capture. A read that lands on the same clock as a new warning change shows whether a set on that edge takes priority over the clear.

// File: rtl/can_fault_pkg.sv
package can_fault_pkg;
    typedef enum logic [1:0] {
        FC_ACTIVE  = 2'd0,
        FC_PASSIVE = 2'd1,
        FC_BUSOFF  = 2'd2
    } fc_state_e;

    typedef enum logic {
        CAP_ARMED = 1'b0,
        CAP_HELD  = 1'b1
    } cap_state_e;

    // flag positions shared by the flag and enable registers
    localparam int IRQ_BUSERR  = 7;
    localparam int IRQ_ARBLOST = 6;
    localparam int IRQ_PASSIVE = 5;
    localparam int IRQ_WARN    = 2;

    typedef struct packed {
        logic [1:0] kind;
        logic       rx_dir;
        logic [4:0] seg;
    } err_code_t;
endpackage

// File: rtl/fault_state_fsm.sv
module fault_state_fsm
    import can_fault_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int PASSIVE_TH = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tec,
    input  logic [CNT_W-1:0] rec,
    input  logic             busoff,
    output logic             passive_o,
    output logic             busoff_o,
    output logic             ep_toggle_o
);
    localparam logic [CNT_W-1:0] TH = CNT_W'(PASSIVE_TH);

    fc_state_e state, nxt;
    logic      over_th;

    assign over_th = (tec >= TH) || (rec >= TH);

    always_comb begin
        nxt = state;
        unique case (state)
            FC_ACTIVE:  if (busoff) nxt = FC_BUSOFF;          // GO_OFF
                        else if (over_th) nxt = FC_PASSIVE;   // GO_PASSIVE
            FC_PASSIVE: if (busoff) nxt = FC_BUSOFF;          // GO_OFF
                        else if (!over_th) nxt = FC_ACTIVE;   // RECOVER
            FC_BUSOFF:  if (!busoff) nxt = over_th ? FC_PASSIVE : FC_ACTIVE; // REJOIN
            default:    nxt = FC_ACTIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FC_ACTIVE;
        else        state <= nxt;
    end

    always_comb begin
        passive_o   = (state == FC_PASSIVE);
        busoff_o    = (state == FC_BUSOFF);
        ep_toggle_o = ((state == FC_ACTIVE)  && (nxt == FC_PASSIVE)) ||
                      ((state == FC_PASSIVE) && (nxt == FC_ACTIVE));
    end
endmodule

// File: rtl/cap_hold.sv
module cap_hold
    import can_fault_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         evt,
    input  logic [W-1:0] din,
    input  logic         rearm,
    output logic [W-1:0] dout,
    output logic         held_o
);
    cap_state_e state, nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            CAP_ARMED: if (evt)   nxt = CAP_HELD;   // LATCH
            CAP_HELD:  if (rearm) nxt = CAP_ARMED;  // REARM
            default:   nxt = CAP_ARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CAP_ARMED;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          dout <= '0;
        else if (state == CAP_ARMED && evt)  dout <= din;
    end

    assign held_o = (state == CAP_HELD);
endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] en_i,
    input  logic         clr_i,
    output logic [N-1:0] flags_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_o <= '0;
        else        flags_o <= (clr_i ? '0 : flags_o) | (set_i & en_i);
    end
endmodule

// File: rtl/can_fault_irq_ctrl.sv
module can_fault_irq_ctrl
    import can_fault_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int IRQ_W      = 8,
    parameter int WARN_RST   = 96,
    parameter int PASSIVE_TH = 128,
    parameter int POS_W      = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tec_i,
    input  logic [CNT_W-1:0] rec_i,
    input  logic             busoff_i,
    input  logic             lim_we,
    input  logic [CNT_W-1:0] lim_wdata,
    input  logic             en_we,
    input  logic [IRQ_W-1:0] en_wdata,
    input  logic             irq_rd,
    input  logic             bus_err_evt,
    input  logic [1:0]       bus_err_type,
    input  logic             bus_err_dir,
    input  logic [4:0]       bus_err_seg,
    input  logic             arb_lost_evt,
    input  logic [POS_W-1:0] arb_lost_pos,
    output logic             err_stat_o,
    output logic             busoff_stat_o,
    output logic             err_passive_o,
    output logic [CNT_W-1:0] warn_lim_o,
    output logic [IRQ_W-1:0] irq_en_o,
    output logic [IRQ_W-1:0] irq_flags_o,
    output logic             irq_o,
    output logic [7:0]       ecc_o,
    output logic [POS_W-1:0] alc_o
);
    localparam logic [CNT_W-1:0] LIM_RST = CNT_W'(WARN_RST);

    logic             err_next, ep_toggle, warn_set;
    logic [IRQ_W-1:0] set_vec;
    err_code_t        code_in;
    logic             ecc_held, alc_held;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      warn_lim_o <= LIM_RST;
        else if (lim_we) warn_lim_o <= lim_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     irq_en_o <= '0;
        else if (en_we) irq_en_o <= en_wdata;
    end

    assign err_next = (tec_i >= warn_lim_o) || (rec_i >= warn_lim_o);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_stat_o <= 1'b0;
        else        err_stat_o <= err_next;
    end

    fault_state_fsm #(.CNT_W(CNT_W), .PASSIVE_TH(PASSIVE_TH)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tec(tec_i), .rec(rec_i), .busoff(busoff_i),
        .passive_o(err_passive_o), .busoff_o(busoff_stat_o), .ep_toggle_o(ep_toggle)
    );

    assign warn_set = (err_next != err_stat_o) || (busoff_i != busoff_stat_o);

    always_comb begin
        set_vec              = '0;
        set_vec[IRQ_BUSERR]  = bus_err_evt;
        set_vec[IRQ_ARBLOST] = arb_lost_evt;
        set_vec[IRQ_PASSIVE] = ep_toggle;
        set_vec[IRQ_WARN]    = warn_set;
    end

    irq_flag_reg #(.N(IRQ_W)) u_flags (
        .clk(clk), .rst_n(rst_n), .set_i(set_vec), .en_i(irq_en_o),
        .clr_i(irq_rd), .flags_o(irq_flags_o)
    );

    assign irq_o = |irq_flags_o;

    assign code_in = '{kind: bus_err_type, rx_dir: bus_err_dir, seg: bus_err_seg};

    cap_hold #(.W(8)) u_ecc (
        .clk(clk), .rst_n(rst_n), .evt(bus_err_evt), .din(code_in),
        .rearm(irq_rd), .dout(ecc_o), .held_o(ecc_held)
    );

    cap_hold #(.W(POS_W)) u_alc (
        .clk(clk), .rst_n(rst_n), .evt(arb_lost_evt), .din(arb_lost_pos),
        .rearm(irq_rd), .dout(alc_o), .held_o(alc_held)
    );
endmodule

// File: rtl/can_fault_irq_chk.sv
module can_fault_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] tec_i,
    input logic [7:0] rec_i,
    input logic       busoff_i,
    input logic       irq_rd,
    input logic       bus_err_evt,
    input logic       arb_lost_evt,
    input logic       err_stat_o,
    input logic       busoff_stat_o,
    input logic       err_passive_o,
    input logic [7:0] warn_lim_o,
    input logic [7:0] irq_en_o,
    input logic [7:0] irq_flags_o,
    input logic [7:0] ecc_o,
    input logic [4:0] alc_o,
    input logic       ecc_held,
    input logic       alc_held
);
    assert_err_stat_R2: assert property (@(posedge clk) disable iff (!rst_n)
        err_stat_o == $past((tec_i >= warn_lim_o) || (rec_i >= warn_lim_o)));

    assert_warn_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (err_stat_o != $past(err_stat_o)) && $past(irq_en_o[2]) |-> irq_flags_o[2]);

    assert_busoff_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busoff_stat_o == $past(busoff_i));

    assert_flag_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flags_o & ~$past(irq_flags_o) & ~$past(irq_en_o)) == 8'h00);

    assert_read_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(irq_rd) && !$past(bus_err_evt) && !$past(arb_lost_evt) &&
        $stable(err_stat_o) && $stable(busoff_stat_o) && $stable(err_passive_o)
        |-> irq_flags_o == 8'h00);

    assert_ecc_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_held && !irq_rd |=> $stable(ecc_o));

    assert_alc_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        alc_held && !irq_rd |=> $stable(alc_o));
endmodule

bind can_fault_irq_ctrl can_fault_irq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tec_i(tec_i), .rec_i(rec_i), .busoff_i(busoff_i),
    .irq_rd(irq_rd), .bus_err_evt(bus_err_evt), .arb_lost_evt(arb_lost_evt),
    .err_stat_o(err_stat_o), .busoff_stat_o(busoff_stat_o),
    .err_passive_o(err_passive_o), .warn_lim_o(warn_lim_o), .irq_en_o(irq_en_o),
    .irq_flags_o(irq_flags_o), .ecc_o(ecc_o), .alc_o(alc_o),
    .ecc_held(ecc_held), .alc_held(alc_held)
);

// File: tb/sim_can_fault_irq_ctrl.sv
`timescale 1ns/1ps
module sim_can_fault_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] tec_i = '0, rec_i = '0;
    logic       busoff_i = 1'b0;
    logic       lim_we = 1'b0;
    logic [7:0] lim_wdata = '0;
    logic       en_we = 1'b0;
    logic [7:0] en_wdata = '0;
    logic       irq_rd = 1'b0;
    logic       bus_err_evt = 1'b0;
    logic [1:0] bus_err_type = '0;
    logic       bus_err_dir = 1'b0;
    logic [4:0] bus_err_seg = '0;
    logic       arb_lost_evt = 1'b0;
    logic [4:0] arb_lost_pos = '0;
    logic       err_stat_o, busoff_stat_o, err_passive_o, irq_o;
    logic [7:0] warn_lim_o, irq_en_o, irq_flags_o, ecc_o;
    logic [4:0] alc_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    can_fault_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .tec_i(tec_i), .rec_i(rec_i), .busoff_i(busoff_i),
        .lim_we(lim_we), .lim_wdata(lim_wdata), .en_we(en_we), .en_wdata(en_wdata),
        .irq_rd(irq_rd), .bus_err_evt(bus_err_evt), .bus_err_type(bus_err_type),
        .bus_err_dir(bus_err_dir), .bus_err_seg(bus_err_seg),
        .arb_lost_evt(arb_lost_evt), .arb_lost_pos(arb_lost_pos),
        .err_stat_o(err_stat_o), .busoff_stat_o(busoff_stat_o),
        .err_passive_o(err_passive_o), .warn_lim_o(warn_lim_o), .irq_en_o(irq_en_o),
        .irq_flags_o(irq_flags_o), .irq_o(irq_o), .ecc_o(ecc_o), .alc_o(alc_o)
    );

    task automatic check(input string req, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got=0x%0h expected=0x%0h", req, got, exp);
        end
    endtask

    // one clock; inputs are always changed 1 ns after an edge
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_read();
        irq_rd = 1'b1;
        tick();
        irq_rd = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 limit", warn_lim_o, 96);
        check("R1 enables", irq_en_o, 0);
        check("R1 flags", irq_flags_o, 0);
        check("R1 status", {err_stat_o, busoff_stat_o, err_passive_o, irq_o}, 0);
        check("R1 captures", {ecc_o, alc_o}, 0);
        en_we = 1'b1; en_wdata = 8'hE4; tick(); en_we = 1'b0;
        check("R6 enable write", irq_en_o, 8'hE4);
    endtask

    task automatic t_warn();
        tec_i = 8'd95; tick();
        check("R2 below limit", err_stat_o, 0);
        check("R3 no change no flag", irq_flags_o, 0);
        tec_i = 8'd96; tick();
        check("R2 at limit", err_stat_o, 1);
        check("R3 rising flag", irq_flags_o, 8'h04);
        check("R10 line up", irq_o, 1);
        do_read();
        check("R7 read clears", irq_flags_o, 0);
        check("R10 line down", irq_o, 0);
        tec_i = 8'd95; tick();
        check("R2 falls", err_stat_o, 0);
        check("R3 falling flag", irq_flags_o, 8'h04);
        do_read();
        tec_i = 8'd0;
        lim_we = 1'b1; lim_wdata = 8'd20; tick(); lim_we = 1'b0;
        check("R2 limit written", warn_lim_o, 20);
        rec_i = 8'd20; tick();
        check("R2 rec at new limit", err_stat_o, 1);
        rec_i = 8'd19; tick();
        check("R2 rec below new limit", err_stat_o, 0);
        do_read();
        lim_we = 1'b1; lim_wdata = 8'd96; tick(); lim_we = 1'b0;
        rec_i = 8'd25; tick();
        check("R2 rec under default", err_stat_o, 0);
        rec_i = 8'd0; tick();
    endtask

    task automatic t_busoff();
        busoff_i = 1'b1; tick();
        check("R4 busoff set", busoff_stat_o, 1);
        check("R4 busoff flag", irq_flags_o, 8'h04);
        check("R5 busoff not passive", err_passive_o, 0);
        do_read();
        busoff_i = 1'b0; tick();
        check("R4 busoff clear", busoff_stat_o, 0);
        check("R4 busoff clear flag", irq_flags_o, 8'h04);
        do_read();
    endtask

    task automatic t_passive();
        tec_i = 8'd127; tick();
        check("R5 127 active", err_passive_o, 0);
        check("R5 127 warn only", irq_flags_o, 8'h04);
        do_read();
        tec_i = 8'd128; tick();
        check("R5 128 passive", err_passive_o, 1);
        check("R5 go passive flag", irq_flags_o, 8'h20);
        do_read();
        tec_i = 8'd100; tick();
        check("R5 recover", err_passive_o, 0);
        check("R5 recover flag", irq_flags_o, 8'h20);
        do_read();
        tec_i = 8'd0; tick();
        check("R5 warn clear only", irq_flags_o, 8'h04);
        do_read();
    endtask

    task automatic t_enable();
        en_we = 1'b1; en_wdata = 8'h00; tick(); en_we = 1'b0;
        tec_i = 8'd100; tick();
        check("R6 masked warn", irq_flags_o, 0);
        check("R10 masked line", irq_o, 0);
        tec_i = 8'd0; tick();
        en_we = 1'b1; en_wdata = 8'h04; tick(); en_we = 1'b0;
        bus_err_evt = 1'b1; tick(); bus_err_evt = 1'b0;
        check("R6 bus error masked", irq_flags_o, 0);
        do_read();
        en_we = 1'b1; en_wdata = 8'hE4; tick(); en_we = 1'b0;
    endtask

    task automatic t_read_collide();
        tec_i = 8'd100; tick();
        check("R7 pre flag", irq_flags_o, 8'h04);
        irq_rd = 1'b1; tec_i = 8'd0; tick(); irq_rd = 1'b0;
        check("R7 set beats clear", irq_flags_o, 8'h04);
        do_read();
        check("R7 cleared", irq_flags_o, 0);
    endtask

    task automatic t_capture();
        bus_err_evt = 1'b1; bus_err_type = 2'b10; bus_err_dir = 1'b1; bus_err_seg = 5'h0A;
        tick();
        bus_err_evt = 1'b0;
        check("R8 stuff rx code", ecc_o, 8'hAA);
        check("R8 bus error flag", irq_flags_o, 8'h80);
        bus_err_evt = 1'b1; bus_err_type = 2'b01; bus_err_dir = 1'b0; bus_err_seg = 5'h03;
        tick();
        bus_err_evt = 1'b0;
        check("R9 code frozen", ecc_o, 8'hAA);
        arb_lost_evt = 1'b1; arb_lost_pos = 5'd17; tick();
        check("R9 arb pos", alc_o, 17);
        check("R9 arb flag", irq_flags_o, 8'hC0);
        arb_lost_pos = 5'd5; tick(); arb_lost_evt = 1'b0;
        check("R9 arb frozen", alc_o, 17);
        do_read();
        bus_err_evt = 1'b1; bus_err_type = 2'b11; bus_err_dir = 1'b0; bus_err_seg = 5'h1F;
        arb_lost_evt = 1'b1; arb_lost_pos = 5'd5;
        tick();
        bus_err_evt = 1'b0; arb_lost_evt = 1'b0;
        check("R8 other tx code after rearm", ecc_o, 8'hDF);
        check("R9 arb after rearm", alc_o, 5);
        do_read();
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();
        t_reset();
        t_warn();
        t_busoff();
        t_passive();
        t_enable();
        t_read_collide();
        t_capture();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got=hung expected=finished");
            summary();
            $finish;
        end
    end
endmodule